// File: doc/BRIEF.md
# Two-Bit-Per-Clock Programmable CRC Engine

This block folds a stream of data words into a cyclic redundancy check whose generator polynomial is set at run time. Software chooses the polynomial order (1 to 32) through a length field and picks which lower-order terms take part through a 32-bit term mask. It sets the width of each data word (1 to 32 bits) through a width field. Words arrive from an upstream buffer over a valid/ready pop interface. The engine consumes two data bits on every clock until no more words are offered, so the throughput is double that of a plain serial shifter.

A separate init strobe loads a starting value into the CRC register while the engine is idle. A go control gates the pop interface. The running remainder is always visible on the result port, and a busy flag marks the cycles in which bits are still being folded in.

Top module: `crc2x_engine`

## Requirements
- R1: `cfg_order_m1` holds the polynomial order minus one, so 5'b01111 gives order 16 and 5'b11111 gives order 32. The result sits in `crc_out[order-1:0]`, and every bit above the order reads zero after any shift cycle or init.
- R2: Bit k of `cfg_taps` (1 ≤ k < order) set means the feedback is XORed into CRC bit k on every step, and cleared means it is not. The x^0 term is always applied, so `cfg_taps[0]` has no effect. The x^order term is implicit, so mask bits at or above the order are ignored.
- R3: `cfg_width_m1` holds the word width W minus one. Each word is consumed most-significant bit first, starting at `wd_data[W-1]`. Bits of `wd_data` at W and above have no effect.
- R4: Every busy cycle folds in two data bits. A word of width W keeps the engine busy for ceil(W/2) cycles, and for odd W its last cycle folds in a single bit.
- R5: `wd_ready` is high only while `go` is high and the engine is either idle or in the last shift cycle of its current word. A pop is a cycle where both `wd_valid` and `wd_ready` are high.
- R6: `busy` rises in the cycle after a pop and falls in the cycle after the last bit of the final word. Words offered back to back leave no idle cycle, so N words of width W take N·ceil(W/2) busy cycles.
- R7: `init_stb` while `busy` is low loads `seed` masked to the order bits into the CRC register in the next cycle. `init_stb` while `busy` is high has no effect on the result.
- R8: While `busy` and `init_stb` are both low, `crc_out` holds its value. With `go` low, no word is popped even if `wd_valid` is high.
- R9: After synchronous reset, `crc_out` is zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_order_m1 | input | 5 | Polynomial order minus one |
| cfg_taps | input | 32 | Term-select mask; bit k adds x^k |
| cfg_width_m1 | input | 5 | Data word width minus one |
| go | input | 1 | Enables popping of words |
| init_stb | input | 1 | Loads the seed while idle |
| seed | input | 32 | Starting CRC value |
| wd_valid | input | 1 | Upstream has a word |
| wd_data | input | 32 | Data word, right-aligned |
| wd_ready | output | 1 | Engine takes the word this cycle |
| crc_out | output | 32 | Current CRC register |
| busy | output | 1 | Bits are being folded in |

## Verification
The bench builds the engine with its default parameters: a 32-bit CRC register, 32-bit data path and two bits per step. At these defaults every order from 1 to 32 and every width from 1 to 32 can be reached at run time. Known check values for the common 16-bit and 32-bit polynomials over bytes and full words are compared alongside random orders, masks and odd widths against a bit-serial model. Bits above the order and above the width are filled at random, so any leakage from them changes the result.

// File: rtl/crc2x_pkg.sv
package crc2x_pkg;

    localparam int CRC_W = 32;
    localparam int ORD_W = $clog2(CRC_W);

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic [ORD_W-1:0] top;   // order minus one
        crc_t             taps;  // feedback terms, already masked
        crc_t             mask;  // valid remainder bits
    } poly_t;

    typedef enum logic {
        FEED_IDLE  = 1'b0,
        FEED_SHIFT = 1'b1
    } feed_state_e;

    function automatic crc_t order_mask(input logic [ORD_W-1:0] top);
        logic [CRC_W:0] w;
        w = ((CRC_W+1)'(2) << top) - (CRC_W+1)'(1);
        return w[CRC_W-1:0];
    endfunction

    function automatic poly_t make_poly(input logic [ORD_W-1:0] top, input crc_t taps);
        poly_t p;
        p.top  = top;
        p.mask = order_mask(top);
        p.taps = (taps | crc_t'(1)) & p.mask;
        return p;
    endfunction

    // One data bit into the remainder, most significant first.
    function automatic crc_t fold_bit(input crc_t c, input logic din, input poly_t p);
        logic fb;
        crc_t n;
        fb = din ^ c[p.top];
        n  = (c << 1) & p.mask;
        if (fb) n = n ^ p.taps;
        return n;
    endfunction

endpackage

// File: rtl/crc_bit_stage.sv
module crc_bit_stage
    import crc2x_pkg::*;
(
    input  crc_t  crc_in,
    input  logic  din,
    input  logic  en,
    input  poly_t poly,
    output crc_t  crc_out
);
    always_comb begin
        crc_out = en ? fold_bit(crc_in, din, poly) : crc_in;
    end
endmodule

// File: rtl/crc_multi_step.sv
module crc_multi_step
    import crc2x_pkg::*;
#(
    parameter int STEPS = 2,
    parameter int CNT_W = 6
) (
    input  crc_t             crc_in,
    input  logic [STEPS-1:0] bits,   // bits[STEPS-1] is folded first
    input  logic [CNT_W-1:0] nbits,
    input  poly_t            poly,
    output crc_t             crc_out
);
    crc_t chain [STEPS+1];

    assign chain[0] = crc_in;

    for (genvar k = 0; k < STEPS; k++) begin : g_stage
        logic en_k;
        assign en_k = (nbits > CNT_W'(k));
        crc_bit_stage u_stage (
            .crc_in (chain[k]),
            .din    (bits[STEPS-1-k]),
            .en     (en_k),
            .poly   (poly),
            .crc_out(chain[k+1])
        );
    end

    assign crc_out = chain[STEPS];
endmodule

// File: rtl/crc_word_feeder.sv
module crc_word_feeder
    import crc2x_pkg::*;
#(
    parameter int DAT_W = 32,
    parameter int STEPS = 2,
    parameter int FLD_W = $clog2(DAT_W),
    parameter int CNT_W = $clog2(DAT_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [FLD_W-1:0] width_m1,
    input  logic             wd_valid,
    input  logic [DAT_W-1:0] wd_data,
    output logic             wd_ready,
    output logic             active,
    output logic [STEPS-1:0] bits,
    output logic [CNT_W-1:0] nbits
);
    localparam logic [FLD_W-1:0] TOP_IDX = FLD_W'(DAT_W - 1);
    localparam logic [CNT_W-1:0] STEP_N  = CNT_W'(STEPS);

    feed_state_e      state_q;
    logic [DAT_W-1:0] buf_q;
    logic [CNT_W-1:0] left_q;
    logic             last_step;
    logic             pop;

    assign active    = (state_q == FEED_SHIFT);
    assign last_step = active && (left_q <= STEP_N);
    assign wd_ready  = go && (!active || last_step);
    assign pop       = wd_ready && wd_valid;
    assign nbits     = !active ? '0 : ((left_q >= STEP_N) ? STEP_N : left_q);
    assign bits      = buf_q[DAT_W-1 -: STEPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FEED_IDLE;
            buf_q   <= '0;
            left_q  <= '0;
        end else if (pop) begin
            state_q <= FEED_SHIFT;
            buf_q   <= wd_data << (TOP_IDX - width_m1);
            left_q  <= CNT_W'(width_m1) + CNT_W'(1);
        end else if (active) begin
            buf_q  <= buf_q << STEPS;
            left_q <= left_q - nbits;
            if (last_step) state_q <= FEED_IDLE;
        end
    end
endmodule

// File: rtl/crc2x_engine.sv
module crc2x_engine
    import crc2x_pkg::*;
#(
    parameter int DAT_W = 32,
    parameter int STEPS = 2,
    parameter int FLD_W = $clog2(DAT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ORD_W-1:0] cfg_order_m1,
    input  logic [CRC_W-1:0] cfg_taps,
    input  logic [FLD_W-1:0] cfg_width_m1,
    input  logic             go,
    input  logic             init_stb,
    input  logic [CRC_W-1:0] seed,
    input  logic             wd_valid,
    input  logic [DAT_W-1:0] wd_data,
    output logic             wd_ready,
    output logic [CRC_W-1:0] crc_out,
    output logic             busy
);
    localparam int CNT_W = $clog2(DAT_W) + 1;

    poly_t            poly;
    crc_t             crc_q;
    crc_t             crc_nxt;
    logic             active;
    logic [STEPS-1:0] bits;
    logic [CNT_W-1:0] nbits;

    assign poly = make_poly(cfg_order_m1, cfg_taps);

    crc_word_feeder #(
        .DAT_W(DAT_W),
        .STEPS(STEPS),
        .FLD_W(FLD_W),
        .CNT_W(CNT_W)
    ) u_feed (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .width_m1(cfg_width_m1),
        .wd_valid(wd_valid),
        .wd_data (wd_data),
        .wd_ready(wd_ready),
        .active  (active),
        .bits    (bits),
        .nbits   (nbits)
    );

    crc_multi_step #(
        .STEPS(STEPS),
        .CNT_W(CNT_W)
    ) u_step (
        .crc_in (crc_q),
        .bits   (bits),
        .nbits  (nbits),
        .poly   (poly),
        .crc_out(crc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (active) begin
            crc_q <= crc_nxt;
        end else if (init_stb) begin
            crc_q <= seed & poly.mask;
        end
    end

    assign crc_out = crc_q;
    assign busy    = active;
endmodule

// File: rtl/crc2x_engine_chk.sv
module crc2x_engine_chk
    import crc2x_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [ORD_W-1:0] cfg_order_m1,
    input logic             go,
    input logic             init_stb,
    input logic [CRC_W-1:0] seed,
    input logic             wd_valid,
    input logic             wd_ready,
    input logic [CRC_W-1:0] crc_out,
    input logic             busy
);
    a_r5_ready_needs_go: assert property (@(posedge clk) disable iff (rst)
        wd_ready |-> go);

    a_r6_pop_starts_busy: assert property (@(posedge clk) disable iff (rst)
        (wd_valid && wd_ready) |=> busy);

    a_r6_busy_rise_from_pop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wd_valid && wd_ready));

    a_r7_init_loads_seed: assert property (@(posedge clk) disable iff (rst)
        (init_stb && !busy) |=> (crc_out == ($past(seed) & order_mask($past(cfg_order_m1)))));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!busy && !init_stb) |=> $stable(crc_out));

    a_r1_high_bits_zero: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((crc_out & ~order_mask($past(cfg_order_m1))) == '0));
endmodule

bind crc2x_engine crc2x_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_order_m1(cfg_order_m1),
    .go          (go),
    .init_stb    (init_stb),
    .seed        (seed),
    .wd_valid    (wd_valid),
    .wd_ready    (wd_ready),
    .crc_out     (crc_out),
    .busy        (busy)
);

// File: tb/tb_crc2x_engine.sv
module tb_crc2x_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cfg_order_m1 = '0;
    logic [31:0] cfg_taps = '0;
    logic [4:0]  cfg_width_m1 = '0;
    logic        go = 1'b0;
    logic        init_stb = 1'b0;
    logic [31:0] seed = '0;
    logic        wd_valid = 1'b0;
    logic [31:0] wd_data = '0;
    logic        wd_ready;
    logic [31:0] crc_out;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    int busy_cyc = 0;
    int cyc      = 0;
    logic [31:0] words [16];

    always #10 clk = ~clk;  // 50 MHz

    crc2x_engine dut (
        .clk(clk), .rst(rst), .cfg_order_m1(cfg_order_m1), .cfg_taps(cfg_taps),
        .cfg_width_m1(cfg_width_m1), .go(go), .init_stb(init_stb), .seed(seed),
        .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
        .crc_out(crc_out), .busy(busy)
    );

    always @(negedge clk) if (busy) busy_cyc++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Independent bit-serial reference.
    function automatic logic [31:0] ref_word(input logic [31:0] c, input logic [31:0] d,
                                             input int w, input int ord, input logic [31:0] taps);
        logic [63:0] m;
        logic [63:0] x;
        logic        fb;
        m = (64'd1 << ord) - 64'd1;
        x = {32'd0, c} & m;
        for (int i = w - 1; i >= 0; i--) begin
            fb = x[ord-1] ^ d[i];
            x  = (x << 1) & m;
            if (fb) x = x ^ (({32'd0, taps} | 64'd1) & m);
        end
        return x[31:0];
    endfunction

    task automatic setup(input int ord, input logic [31:0] taps, input int w, input logic [31:0] s);
        @(negedge clk);
        cfg_order_m1 = 5'(ord - 1);
        cfg_taps     = taps;
        cfg_width_m1 = 5'(w - 1);
        seed         = s;
        init_stb     = 1'b1;
        @(negedge clk);
        init_stb     = 1'b0;
    endtask

    task automatic send(input int n);
        busy_cyc = 0;
        go = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (i == 0) @(negedge clk);
            wd_valid = 1'b1;
            wd_data  = words[i];
            #1;
            while (!wd_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        wd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        logic [31:0] exp;
        logic [31:0] hold;
        int ord, w, n;
        logic [31:0] taps;
        void'($urandom(32'h5eed_c0de));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(crc_out == 0, "R9 reset crc", crc_out, 0);
        check(busy == 0, "R9 reset busy", {31'd0, busy}, 0);

        // R8: go low blocks popping
        wd_valid = 1'b1;
        wd_data  = 32'hA5;
        repeat (4) @(negedge clk);
        check(wd_ready == 0 && busy == 0, "R8 go low no pop", {30'd0, wd_ready, busy}, 0);
        check(crc_out == 0, "R8 idle hold", crc_out, 0);
        wd_valid = 1'b0;

        // R7: init masked to order 16
        setup(16, 32'h1021, 8, 32'hFFFF_FFFF);
        check(crc_out == 32'h0000_FFFF, "R7 R1 seed masked", crc_out, 32'h0000_FFFF);

        // R1 R2 R3: order 16 over bytes "123456789", x^0 bit left clear in mask
        setup(16, 32'h1020, 8, 32'hFFFF);
        for (int i = 0; i < 9; i++) words[i] = 32'h31 + i;
        send(9);
        check(crc_out == 32'h29B1, "R2 16-bit byte check value", crc_out, 32'h29B1);
        check(busy_cyc == 36, "R6 back-to-back bytes", busy_cyc, 36);

        // R1 R2: order 32 over the same bytes
        setup(32, 32'h04C1_1DB7, 8, 32'hFFFF_FFFF);
        send(9);
        check(crc_out == 32'h0376_E6E7, "R1 32-bit byte check value", crc_out, 32'h0376_E6E7);

        // R3: full 32-bit words, MSB first, matches byte order
        setup(32, 32'h04C1_1DB7, 32, 32'hFFFF_FFFF);
        words[0] = 32'h3132_3334;
        words[1] = 32'h3536_3738;
        send(2);
        exp = ref_word(32'hFFFF_FFFF, 32'h3132_3334, 32, 32, 32'h04C1_1DB7);
        exp = ref_word(exp, 32'h3536_3738, 32, 32, 32'h04C1_1DB7);
        check(crc_out == exp, "R3 32-bit words", crc_out, exp);
        check(busy_cyc == 32, "R4 two words of 32 bits", busy_cyc, 32);

        // R4: single word of width 1 (one cycle, one bit)
        setup(16, 32'h1021, 1, 32'h1234);
        words[0] = 32'hFFFF_FFFF;
        send(1);
        exp = ref_word(32'h1234, 32'h1, 1, 16, 32'h1021);
        check(crc_out == exp, "R4 width 1", crc_out, exp);
        check(busy_cyc == 1, "R4 width 1 cycles", busy_cyc, 1);

        // R7: init while busy is ignored
        setup(32, 32'h04C1_1DB7, 32, 32'h0);
        go = 1'b1;
        wd_valid = 1'b1;
        wd_data = 32'hCAFE_F00D;
        @(negedge clk);
        wd_valid = 1'b0;
        seed = 32'hDEAD_BEEF;
        init_stb = 1'b1;
        @(negedge clk);
        init_stb = 1'b0;
        while (busy) @(negedge clk);
        exp = ref_word(32'h0, 32'hCAFE_F00D, 32, 32, 32'h04C1_1DB7);
        check(crc_out == exp, "R7 init ignored while busy", crc_out, exp);

        // R8: idle with no init keeps result
        hold = crc_out;
        go = 1'b0;
        repeat (5) @(negedge clk);
        check(crc_out == hold, "R8 idle hold after run", crc_out, hold);

        // Random orders, masks, widths; junk above width and order
        for (int t = 0; t < 40; t++) begin
            ord  = 1 + ($urandom % 32);
            w    = 1 + ($urandom % 32);
            n    = 1 + ($urandom % 6);
            taps = $urandom;
            hold = $urandom;
            setup(ord, taps, w, hold);
            exp = hold & 32'((64'd1 << ord) - 64'd1);
            for (int i = 0; i < n; i++) begin
                words[i] = $urandom;
                exp = ref_word(exp, words[i] & 32'((64'd1 << w) - 64'd1), w, ord, taps);
            end
            send(n);
            check(crc_out == exp, "R3 R2 random run", crc_out, exp);
            check(busy_cyc == n * ((w + 1) / 2), "R4 R6 random busy cycles",
                  busy_cyc, n * ((w + 1) / 2));
        end

        go = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule